// File: doc/BRIEF.md
# Pulse Edge Timestamp Capture

This block watches one digital pulse line and stamps it against a shared free-running time value. When the line goes high the block stores the time value as the leading stamp. When the line goes low again it stores the time value as the trailing stamp. It then offers the stamp pair to a downstream consumer over a two-wire request/acknowledge handshake.

The pin first passes through a short shift register. The leading stages resynchronise it and the final stage keeps one cycle of history, so edges show up as a difference between the last two taps. After a pair is captured, the block sits in dead time and ignores the pin. It leaves dead time only when the consumer has acknowledged the pair and then dropped its acknowledge. A run input from the control register pauses the channel, and an active-low reset clears it. The time source is external; the block only samples it.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset `offer_req` is 0, both stamps read 0, and the block waits for a rising edge.
- R2: With a pin change made ahead of clock edge k, the leading stamp equals the `time_now` value held between clock edges k+1 and k+2. This is a latency of 2 cycles.
- R3: The trailing stamp follows the same 2-cycle latency rule, applied to the falling edge of the pin.
- R4: `offer_req` goes to 1 at clock edge k+2, where k is the first edge that samples the falling pin. It is 0 before that edge.
- R5: `offer_req` stays at 1 and both stamps stay constant until `offer_ack` is sampled at 1. `offer_req` returns to 0 one cycle later.
- R6: Pulses that arrive while a pair is being offered, or while `offer_ack` is still high, are ignored. The stamps do not change and no new request appears.
- R7: The block re-arms only after `offer_ack` has returned to 0. A pulse after that point is captured normally.
- R8: While `run` is 0, pulses are ignored entirely. No request is raised and the stamps do not change.
- R9: If `run` drops while the block waits for a falling edge, the partial pulse is abandoned. The later falling edge raises no request.
- R10: A pulse that is high for a single clock cycle is still captured. Its trailing stamp is one count above its leading stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset from the control register |
| run | input | 1 | 1 lets the channel capture; 0 pauses it |
| pulse_pin | input | 1 | Asynchronous pulse input |
| time_now | input | TIME_W | Shared time value |
| offer_req | output | 1 | High while a stamp pair is offered |
| offer_ack | input | 1 | Consumer acknowledge |
| lead_stamp | output | TIME_W | Time value at the leading edge |
| trail_stamp | output | TIME_W | Time value at the trailing edge |

## Verification
The assertions assume that the consumer raises `offer_ack` only in answer to a request and holds it until it sees the request drop. They also assume that the pin is low when reset is released, so the history stage starts out matching the line. The bench follows both rules. It raises acknowledge only while the request is high and lowers it only after the request has dropped. It holds the pin low through reset. It drives the pin, run and acknowledge on falling clock edges only.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
   typedef enum logic [1:0] {
      ST_WAIT_RISE = 2'd0,
      ST_WAIT_FALL = 2'd1,
      ST_OFFER     = 2'd2,
      ST_RELEASE   = 2'd3
   } stamp_state_t;
endpackage

// File: rtl/edge_stamp_sync.sv
module edge_stamp_sync #(
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_LOW  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int TAPS = SYNC_STAGES + 1;
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("edge_stamp_sync: SYNC_STAGES must be at least 2");
   end

   logic            pin_c;
   logic [TAPS-1:0] taps;

   if (ACTIVE_LOW) begin : g_inv
      assign pin_c = ~pin;
   end else begin : g_pass
      assign pin_c = pin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[0] <= 1'b0;
      else        taps[0] <= pin_c;
   end

   for (genvar g = 1; g < TAPS; g++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) taps[g] <= 1'b0;
         else        taps[g] <= taps[g-1];
      end
   end

   assign rise = taps[LAST] & ~taps[SYNC_STAGES];
   assign fall = ~taps[LAST] & taps[SYNC_STAGES];

   // R2: each level change yields exactly one detection cycle
   assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   assert_single_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/edge_stamp_fsm.sv
module edge_stamp_fsm
   import edge_stamp_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         rise,
   input  logic         fall,
   input  logic         ack,
   output stamp_state_t state,
   output logic         load_lead,
   output logic         load_trail,
   output logic         req
);
   stamp_state_t state_nx;

   always_comb begin
      state_nx   = state;
      load_lead  = 1'b0;
      load_trail = 1'b0;
      unique case (state)
         ST_WAIT_RISE: if (run && rise) begin
            load_lead = 1'b1;
            state_nx  = ST_WAIT_FALL;
         end
         ST_WAIT_FALL: if (!run) begin
            state_nx = ST_WAIT_RISE;
         end else if (fall) begin
            load_trail = 1'b1;
            state_nx   = ST_OFFER;
         end
         ST_OFFER:     if (ack)  state_nx = ST_RELEASE;
         ST_RELEASE:   if (!ack) state_nx = ST_WAIT_RISE;
         default:      state_nx = ST_WAIT_RISE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_WAIT_RISE;
      else        state <= state_nx;
   end

   assign req = (state == ST_OFFER);

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> req);
   assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack) |=> !req);
   assert_rearm_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RELEASE && ack) |=> state == ST_RELEASE);
   assert_pause_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && state == ST_WAIT_RISE) |=> state == ST_WAIT_RISE);
   assert_abandon_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && state == ST_WAIT_FALL) |=> state == ST_WAIT_RISE);
endmodule

// File: rtl/edge_stamp_hold.sv
module edge_stamp_hold #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_lead,
   input  logic              load_trail,
   input  logic [TIME_W-1:0] time_now,
   output logic [TIME_W-1:0] lead,
   output logic [TIME_W-1:0] trail
);
   if (TIME_W < 1) begin : g_bad_width
      $error("edge_stamp_hold: TIME_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead  <= '0;
         trail <= '0;
      end else begin
         if (load_lead)  lead  <= time_now;
         if (load_trail) trail <= time_now;
      end
   end

   // R3: the two stamps of one pulse are never loaded together
   assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_lead && load_trail));
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
   import edge_stamp_pkg::*;
#(
   parameter int TIME_W      = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_LOW  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              pulse_pin,
   input  logic [TIME_W-1:0] time_now,
   output logic              offer_req,
   input  logic              offer_ack,
   output logic [TIME_W-1:0] lead_stamp,
   output logic [TIME_W-1:0] trail_stamp
);
   logic         rise, fall, load_lead, load_trail;
   stamp_state_t state;

   edge_stamp_sync #(.SYNC_STAGES(SYNC_STAGES), .ACTIVE_LOW(ACTIVE_LOW)) u_sync (
      .clk (clk), .rst_n (rst_n), .pin (pulse_pin), .rise (rise), .fall (fall)
   );

   edge_stamp_fsm u_fsm (
      .clk (clk), .rst_n (rst_n), .run (run), .rise (rise), .fall (fall),
      .ack (offer_ack), .state (state), .load_lead (load_lead),
      .load_trail (load_trail), .req (offer_req)
   );

   edge_stamp_hold #(.TIME_W(TIME_W)) u_hold (
      .clk (clk), .rst_n (rst_n), .load_lead (load_lead), .load_trail (load_trail),
      .time_now (time_now), .lead (lead_stamp), .trail (trail_stamp)
   );

   assert_stamp_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (offer_req && !offer_ack) |=> ($stable(lead_stamp) && $stable(trail_stamp)));
   assert_pause_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(lead_stamp) && $stable(trail_stamp)));
   assert_dead_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RELEASE) |=> $stable(lead_stamp));
endmodule

// File: tb/test_edge_stamp_capture.sv
module test_edge_stamp_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b1;
   logic        pin = 1'b0;
   logic        ack = 1'b0;
   logic [63:0] tc = 64'h0000_00FF_FFFF_FFF8;
   logic        req;
   logic [63:0] lead, trail;
   int          tests = 0;
   int          failed = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) tc <= tc + 64'd1;

   edge_stamp_capture i_edge_stamp_capture (
      .clk (clk), .rst_n (rst_n), .run (run), .pulse_pin (pin), .time_now (tc),
      .offer_req (req), .offer_ack (ack), .lead_stamp (lead), .trail_stamp (trail)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive a pulse of width w cycles; returns time values seen at each drive
   task automatic pulse(input int w, output logic [63:0] t_up, output logic [63:0] t_dn);
      pin = 1'b1; t_up = tc;
      step(w);
      pin = 1'b0; t_dn = tc;
   endtask

   task automatic handshake(input string tag);
      ack = 1'b1;
      step(1);
      chk(req == 1'b0, tag, 64'(req), 64'd0);
      ack = 1'b0;
      step(2);
   endtask

   task automatic t_reset;
      chk(req == 1'b0, "R1 req", 64'(req), 64'd0);
      chk(lead == 64'd0, "R1 lead", lead, 64'd0);
      chk(trail == 64'd0, "R1 trail", trail, 64'd0);
   endtask

   task automatic t_basic;
      logic [63:0] tu, td;
      pulse(5, tu, td);
      step(2);
      chk(req == 1'b0, "R4 early", 64'(req), 64'd0);
      step(1);
      chk(req == 1'b1, "R4 req", 64'(req), 64'd1);
      chk(lead == tu + 64'd2, "R2 lead", lead, tu + 64'd2);
      chk(trail == td + 64'd2, "R3 trail", trail, td + 64'd2);
      step(6);
      chk(req == 1'b1, "R5 hold", 64'(req), 64'd1);
      chk(lead == tu + 64'd2, "R5 lead stable", lead, tu + 64'd2);
      handshake("R5 drop");
   endtask

   task automatic t_dead;
      logic [63:0] tu, td, l0, t0, xu, xd;
      pulse(3, tu, td);
      step(3);
      l0 = lead; t0 = trail;
      chk(req == 1'b1, "R6 offer", 64'(req), 64'd1);
      pulse(3, xu, xd);
      step(5);
      chk(lead == l0, "R6 lead during offer", lead, l0);
      chk(trail == t0, "R6 trail during offer", trail, t0);
      ack = 1'b1;
      step(1);
      pulse(2, xu, xd);
      step(5);
      chk(req == 1'b0, "R6 no req while ack", 64'(req), 64'd0);
      chk(lead == l0, "R6 lead while ack", lead, l0);
      ack = 1'b0;
      step(3);
      chk(req == 1'b0, "R7 no spurious req", 64'(req), 64'd0);
      pulse(4, tu, td);
      step(3);
      chk(req == 1'b1, "R7 rearmed", 64'(req), 64'd1);
      chk(lead == tu + 64'd2, "R7 lead", lead, tu + 64'd2);
      chk(trail == td + 64'd2, "R7 trail", trail, td + 64'd2);
      handshake("R7 drop");
   endtask

   task automatic t_pause;
      logic [63:0] tu, td, l0, t0;
      l0 = lead; t0 = trail;
      run = 1'b0;
      step(1);
      pulse(4, tu, td);
      step(5);
      chk(req == 1'b0, "R8 no req", 64'(req), 64'd0);
      chk(lead == l0, "R8 lead", lead, l0);
      chk(trail == t0, "R8 trail", trail, t0);
      run = 1'b1;
      step(2);
   endtask

   task automatic t_abandon;
      logic [63:0] tu, td;
      pin = 1'b1;
      step(5);
      run = 1'b0;
      step(1);
      run = 1'b1;
      step(2);
      pin = 1'b0;
      step(5);
      chk(req == 1'b0, "R9 abandoned", 64'(req), 64'd0);
      pulse(3, tu, td);
      step(3);
      chk(req == 1'b1, "R9 next pulse", 64'(req), 64'd1);
      chk(lead == tu + 64'd2, "R9 lead", lead, tu + 64'd2);
      handshake("R9 drop");
   endtask

   task automatic t_short;
      logic [63:0] tu, td;
      pulse(1, tu, td);
      step(3);
      chk(req == 1'b1, "R10 req", 64'(req), 64'd1);
      chk(lead == tu + 64'd2, "R10 lead", lead, tu + 64'd2);
      chk(trail == lead + 64'd1, "R10 trail", trail, lead + 64'd1);
      handshake("R10 drop");
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_basic();
      t_dead();
      t_pause();
      t_abandon();
      t_short();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         tests++;
         failed++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end
endmodule